// File: doc/BRIEF.md
# Tear-Free 48-bit Seconds Counter

This block keeps wall-clock time as a 48-bit count of seconds. A free-running tick enable at the nominal 32.768 kHz reference rate feeds a sub-second prescaler. Each time the prescaler completes a second, the count advances by one. Software sees the count through two 32-bit registers. The lower register carries bits 31:0. The upper register carries bits 47:32 in its low 16 bits. A control register and a signed compensation register sit beside them.

A 32-bit bus reads the count in two halves, and the count can carry between the two reads. To prevent a torn value, software selects a freeze mode in the control register. In that mode, a read of the lower register captures the upper half at the same instant, and reads of the upper register return the captured half until one of them releases it.

Software sets the time by staging the lower half and then the upper half. The staged time replaces the count at the next second boundary. The compensation register trims the rate once per hour-long window. A positive value swallows reference ticks and a negative value adds ticks.

Top module: `tearfree_seconds`

## Requirements
- R1: After reset, the count, the prescaler, the hour window, the freeze state, the control register and the compensation register are all zero, so every register reads 0.
- R2: The count advances by exactly one when TICKS_PER_SEC effective ticks have accumulated, and it wraps from all ones to zero modulo 2^48. It changes at no other time except for a load.
- R3: The register at address 0 reads the count bits 31:0. The register at address 1 reads bits 47:32 in bits 15:0, and its bits 31:16 always read 0. Read data follows busAddr combinationally.
- R4: When control bits 25:24 hold the value 2, a read strobe on address 0 captures the upper half at that cycle. Later reads of address 1 return the captured value even if the live count carries.
- R5: A read strobe on address 1 releases the capture. Afterwards, address 1 shows the live upper half until the next capturing read of address 0. With any other mode value, a read of address 0 captures nothing.
- R6: A write to address 0 stages the low half. A write to address 1 stages bits 15:0 as the high half and arms a load, and its bits 31:16 are ignored. At the next second boundary, the count takes the staged value instead of incrementing, and the prescaler starts again at zero.
- R7: The compensation register (address 3) is sampled at the end of every window of TICKS_PER_SEC*SECS_PER_WINDOW reference ticks. A positive value N then causes the next N reference ticks to be discarded.
- R8: A negative compensation value -N, sampled at a window end, causes N extra ticks to be counted. Each extra tick is taken on a following clock cycle on which tickEn is low.
- R9: The control register (address 2) reads back its 2-bit mode in bits 25:24 and zero elsewhere. The compensation register reads back all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous active-low reset |
| tickEn | input | 1 | One-cycle pulse per reference tick |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (drives freeze side effects) |
| busAddr | input | 2 | Register select: 0 low, 1 high, 2 control, 3 compensation |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr |

## Verification
The assertions check on every cycle that the count moves only at a second boundary, by one or to the staged value. They also check that a held capture stays still until it is recaptured, that an upper-register read always releases the capture, and that the upper read word has zero padding. Whether the right ticks are swallowed or inserted after a window end, and whether a low-then-high read pair stays coherent across a real carry, can only be shown by the bench's scenarios. There, a behavioural model tracks the tick budget and the captured half, and it predicts the read data on every cycle.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
  typedef enum logic [1:0] {
    ADDR_LO   = 2'd0,
    ADDR_HI   = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_COMP = 2'd3
  } regAddr_t;

  localparam logic [1:0] FREEZE_ON_LO = 2'd2;
  localparam int         FMODE_LSB    = 24;

  typedef struct packed {
    logic effTick;    // counted tick after compensation
    logic captureHi;  // snapshot the live upper half now
    logic holdSnap;   // snapshot is held (frozen)
    logic loadArmed;  // staged time waits for the next boundary
  } strobes_t;
endpackage

// File: rtl/tfs_datapath.sv
module tfs_datapath
  import tfs_pkg::*;
#(
  parameter  int TICKS_PER_SEC   = 32768,
  parameter  int SECS_PER_WINDOW = 3600,
  parameter  int CNT_W           = 48,
  localparam int HI_W            = CNT_W - 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  strobes_t         strb,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] count,
  output logic [HI_W-1:0]  snapHi,
  output logic             secWrap,
  output logic             windowEnd
);
  localparam int PRE_W     = $clog2(TICKS_PER_SEC);
  localparam int WIN_TICKS = TICKS_PER_SEC * SECS_PER_WINDOW;
  localparam int WIN_W     = $clog2(WIN_TICKS);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_SEC - 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_TICKS - 1);

  logic [PRE_W-1:0] presc;
  logic [WIN_W-1:0] winCnt;

  assign secWrap   = strb.effTick && (presc == PRE_LAST);
  assign windowEnd = tickEn && (winCnt == WIN_LAST);

  // sub-second prescaler, advanced by compensated ticks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      presc <= '0;
    end else if (strb.effTick) begin
      presc <= secWrap ? '0 : presc + PRE_W'(1);
    end
  end

  // hour window, advanced by raw reference ticks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (tickEn) begin
      winCnt <= windowEnd ? '0 : winCnt + WIN_W'(1);
    end
  end

  // seconds count: increment or take the staged time at a boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (secWrap) begin
      count <= strb.loadArmed ? loadValue : count + CNT_W'(1);
    end
  end

  // upper-half snapshot: follows live value unless held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapHi <= '0;
    end else if (strb.captureHi || !strb.holdSnap) begin
      snapHi <= count[CNT_W-1:32];
    end
  end
endmodule

// File: rtl/tfs_control.sv
module tfs_control
  import tfs_pkg::*;
#(
  parameter  int CNT_W = 48,
  localparam int HI_W  = CNT_W - 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [1:0]       busAddr,
  input  logic [31:0]      busWrData,
  input  logic [CNT_W-1:0] count,
  input  logic [HI_W-1:0]  snapHi,
  input  logic             secWrap,
  input  logic             windowEnd,
  output strobes_t         strb,
  output logic [CNT_W-1:0] loadValue,
  output logic [31:0]      busRdData
);
  logic [1:0]      mode;
  logic [31:0]     comp;
  logic            frozen;
  logic [31:0]     stageLo;
  logic [HI_W-1:0] stageHi;
  logic            loadPending;
  logic [31:0]     dropCred;
  logic [31:0]     insCred;

  logic rdLo, rdHi, wrLo, wrHi, wrCtrl, wrComp;
  logic compNeg;
  logic [31:0] compMag;

  assign rdLo   = busRd && (busAddr == ADDR_LO);
  assign rdHi   = busRd && (busAddr == ADDR_HI);
  assign wrLo   = busWr && (busAddr == ADDR_LO);
  assign wrHi   = busWr && (busAddr == ADDR_HI);
  assign wrCtrl = busWr && (busAddr == ADDR_CTRL);
  assign wrComp = busWr && (busAddr == ADDR_COMP);

  assign compNeg = comp[31];
  assign compMag = compNeg ? (~comp + 32'd1) : comp;

  always_comb begin
    strb.effTick   = tickEn ? (dropCred == '0) : (insCred != '0);
    strb.captureHi = rdLo && (mode == FREEZE_ON_LO);
    strb.holdSnap  = frozen;
    strb.loadArmed = loadPending;
  end

  assign loadValue = {stageHi, stageLo};

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode <= '0;
      comp <= '0;
    end else begin
      if (wrCtrl) mode <= busWrData[FMODE_LSB +: 2];
      if (wrComp) comp <= busWrData;
    end
  end

  // freeze state: set by capturing low read, released by high read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frozen <= 1'b0;
    end else if (strb.captureHi) begin
      frozen <= 1'b1;
    end else if (rdHi) begin
      frozen <= 1'b0;
    end
  end

  // staged time and load arming
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageLo     <= '0;
      stageHi     <= '0;
      loadPending <= 1'b0;
    end else begin
      if (wrLo) stageLo <= busWrData;
      if (wrHi) begin
        stageHi     <= busWrData[HI_W-1:0];
        loadPending <= 1'b1;
      end else if (secWrap) begin
        loadPending <= 1'b0;
      end
    end
  end

  // compensation credits, reloaded at each window end
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dropCred <= '0;
      insCred  <= '0;
    end else if (windowEnd) begin
      dropCred <= compNeg ? '0 : comp;
      insCred  <= compNeg ? compMag : '0;
    end else if (tickEn && (dropCred != '0)) begin
      dropCred <= dropCred - 32'd1;
    end else if (!tickEn && (insCred != '0)) begin
      insCred <= insCred - 32'd1;
    end
  end

  // read mux
  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_LO:   busRdData = count[31:0];
      ADDR_HI:   busRdData[HI_W-1:0] = frozen ? snapHi : count[CNT_W-1:32];
      ADDR_CTRL: busRdData[FMODE_LSB +: 2] = mode;
      ADDR_COMP: busRdData = comp;
      default:   busRdData = '0;
    endcase
  end
endmodule

// File: rtl/tearfree_seconds.sv
module tearfree_seconds
  import tfs_pkg::*;
#(
  parameter int TICKS_PER_SEC   = 32768,
  parameter int SECS_PER_WINDOW = 3600,
  parameter int CNT_W           = 48
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [1:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData
);
  localparam int HI_W = CNT_W - 32;

  strobes_t         strb;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] loadValue;
  logic [HI_W-1:0]  snapHi;
  logic             secWrap;
  logic             windowEnd;

  tfs_control #(.CNT_W(CNT_W)) u_control (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWrData(busWrData),
    .count(count), .snapHi(snapHi), .secWrap(secWrap), .windowEnd(windowEnd),
    .strb(strb), .loadValue(loadValue), .busRdData(busRdData)
  );

  tfs_datapath #(
    .TICKS_PER_SEC(TICKS_PER_SEC), .SECS_PER_WINDOW(SECS_PER_WINDOW), .CNT_W(CNT_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb), .loadValue(loadValue),
    .count(count), .snapHi(snapHi), .secWrap(secWrap), .windowEnd(windowEnd)
  );
endmodule

// File: rtl/tfs_checker.sv
module tfs_checker
  import tfs_pkg::*;
#(
  parameter  int CNT_W = 48,
  localparam int HI_W  = CNT_W - 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             busRd,
  input logic [1:0]       busAddr,
  input logic [31:0]      busRdData,
  input strobes_t         strb,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] loadValue,
  input logic [HI_W-1:0]  snapHi,
  input logic             secWrap
);
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !secWrap |=> count == $past(count));

  a_r2_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (secWrap && !strb.loadArmed) |=> count == $past(count) + CNT_W'(1));

  a_r6_load_lands: assert property (@(posedge clk) disable iff (!rstN)
    (secWrap && strb.loadArmed) |=> count == $past(loadValue));

  a_r4_snap_held: assert property (@(posedge clk) disable iff (!rstN)
    (strb.holdSnap && !strb.captureHi) |=> $stable(snapHi));

  a_r5_hi_read_releases: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == ADDR_HI) |=> !strb.holdSnap);

  a_r3_hi_padding: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_HI) |-> busRdData[31:HI_W] == '0);
endmodule

bind tearfree_seconds tfs_checker #(.CNT_W(CNT_W)) u_tfsChecker (
  .clk(clk), .rstN(rstN), .busRd(busRd), .busAddr(busAddr), .busRdData(busRdData),
  .strb(strb), .count(count), .loadValue(loadValue), .snapHi(snapHi), .secWrap(secWrap)
);

// File: tb/tearfree_seconds_bench.sv
module tearfree_seconds_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 4;
  localparam int SPW = 3;
  localparam int WIN = TPS * SPW;

  logic clk = 1'b0;
  logic rstN, tickEn, busWr, busRd;
  logic [1:0]  busAddr;
  logic [31:0] busWrData;
  logic [31:0] busRdData;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tearfree_seconds #(.TICKS_PER_SEC(TPS), .SECS_PER_WINDOW(SPW), .CNT_W(48)) u_tearfree_seconds (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData)
  );

  // behavioural reference model
  logic [47:0] mCount;
  logic [15:0] mSnap, mStHi;
  logic [31:0] mStLo;
  logic [1:0]  mMode;
  int          mComp;
  longint      mDrop, mIns;
  int          mPresc, mWin;
  bit          mFrozen, mPend;

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = '0; mSnap = '0; mStHi = '0; mStLo = '0; mMode = '0; mComp = 0;
      mDrop = 0; mIns = 0; mPresc = 0; mWin = 0; mFrozen = 0; mPend = 0;
    end else begin
      logic [15:0] oldHi;
      bit eff, winEnd;
      oldHi  = mCount[47:32];
      winEnd = tickEn && (mWin == WIN - 1);
      eff    = tickEn ? (mDrop == 0) : (mIns != 0);
      if (winEnd) begin
        mDrop = (mComp > 0) ? longint'(mComp) : 0;
        mIns  = (mComp < 0) ? -longint'(mComp) : 0;
      end else if (tickEn && mDrop != 0) mDrop--;
      else if (!tickEn && mIns != 0) mIns--;
      if (tickEn) mWin = winEnd ? 0 : mWin + 1;
      if (eff) begin
        if (mPresc == TPS - 1) begin
          mPresc = 0;
          mCount = mPend ? {mStHi, mStLo} : mCount + 48'd1;
          mPend  = 0;
        end else mPresc++;
      end
      if (busWr) begin
        case (busAddr)
          2'd0: mStLo = busWrData;
          2'd1: begin mStHi = busWrData[15:0]; mPend = 1; end
          2'd2: mMode = busWrData[25:24];
          default: mComp = busWrData;
        endcase
      end
      if (busRd && busAddr == 2'd0 && mMode == 2'd2) begin
        mFrozen = 1; mSnap = oldHi;
      end else if (busRd && busAddr == 2'd1) mFrozen = 0;
    end
  end

  function automatic logic [31:0] expRead(input logic [1:0] a);
    case (a)
      2'd0:    return mCount[31:0];
      2'd1:    return {16'h0, mFrozen ? mSnap : mCount[47:32]};
      2'd2:    return {6'h0, mMode, 24'h0};
      default: return mComp;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h (t=%0t)", req, got, exp, $time);
    end
  endtask

  // one clock of stimulus, then compare read data with the model
  task automatic step(input logic t, input logic wr, input logic rd,
                      input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    tickEn = t; busWr = wr; busRd = rd; busAddr = a; busWrData = d;
    #1;
    chk(curReq, busRdData, expRead(busAddr));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev;
    rstN = 1'b0; tickEn = 0; busWr = 0; busRd = 0; busAddr = 0; busWrData = 0;
    for (int i = 0; i < 3; i++) step(1, 0, 0, 2'(i), 0);
    @(negedge clk); rstN = 1'b1;
    // R1: reset values
    curReq = "R1";
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 0, 2'(i), 0);
      chk("R1", busRdData, 32'h0);
    end
    // R2: plain counting, tick every cycle
    curReq = "R2";
    for (int i = 0; i < 30; i++) step(1, 0, 0, 2'd0, 0);
    chk("R2", busRdData, 32'd7);
    // R9: control and compensation readback
    curReq = "R9";
    step(0, 1, 0, 2'd2, 32'hFFFF_FFFF);
    step(0, 0, 0, 2'd2, 0);
    chk("R9", busRdData, 32'h0300_0000);
    step(0, 1, 0, 2'd3, 32'hA5A5_0000);
    step(0, 0, 0, 2'd3, 0);
    chk("R9", busRdData, 32'hA5A5_0000);
    step(0, 1, 0, 2'd3, 32'h0);
    // R5: non-freeze mode: low read captures nothing
    curReq = "R5";
    step(0, 0, 1, 2'd0, 0);
    step(0, 0, 1, 2'd1, 0);
    // R6: load with junk in high bits 31:16
    curReq = "R6";
    step(0, 1, 0, 2'd2, 32'h0200_0000);
    step(0, 1, 0, 2'd0, 32'hFFFF_FFFE);
    step(0, 1, 0, 2'd1, 32'h1234_0005);
    prev = busRdData;
    step(0, 0, 0, 2'd0, 0);
    prev = busRdData;
    for (int i = 0; i < 10; i++) begin
      step(1, 0, 0, 2'd0, 0);
      if (busRdData != prev) break;
    end
    chk("R6", busRdData, 32'hFFFF_FFFE);
    for (int i = 0; i < TPS - 1; i++) step(1, 0, 0, 2'd0, 0);
    step(0, 0, 0, 2'd0, 0);
    chk("R2", busRdData, 32'hFFFF_FFFF);
    step(0, 0, 0, 2'd1, 0);
    chk("R6", busRdData, 32'h0000_0005);
    // R4: freeze across a carry
    curReq = "R4";
    step(0, 0, 1, 2'd0, 0);
    chk("R4", busRdData, 32'hFFFF_FFFF);
    for (int i = 0; i < 2 * TPS; i++) step(1, 0, 0, 2'd1, 0);
    step(0, 0, 1, 2'd1, 0);
    chk("R4", busRdData, 32'h0000_0005);
    curReq = "R5";
    step(0, 0, 1, 2'd1, 0);
    chk("R5", busRdData, 32'h0000_0006);
    // R2: wrap at 2^48
    curReq = "R2";
    step(0, 1, 0, 2'd0, 32'hFFFF_FFFF);
    step(0, 1, 0, 2'd1, 32'h0000_FFFF);
    for (int i = 0; i < 3 * TPS; i++) step(1, 0, 0, 2'd1, 0);
    step(0, 0, 0, 2'd1, 0);
    chk("R2", busRdData, 32'h0);
    // R7: positive compensation drops ticks
    curReq = "R7";
    step(0, 1, 0, 2'd3, 32'd2);
    for (int i = 0; i < 4 * WIN; i++) step(1, 0, 0, 2'(i % 2), 0);
    // R8: negative compensation inserts ticks on idle cycles
    curReq = "R8";
    step(0, 1, 0, 2'd3, 32'hFFFF_FFFD);
    for (int i = 0; i < 8 * WIN; i++) step(i % 2 == 0, 0, 0, 2'd0, 0);
    // R4 again: freeze under compensation, with recapture
    curReq = "R4";
    step(0, 0, 1, 2'd0, 0);
    for (int i = 0; i < 3 * TPS; i++) step(1, 0, i == 5, 2'd0, 0);
    step(0, 0, 1, 2'd1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule